// File: doc/BRIEF.md
# Pipeline Barrier and Refetch Controller

This block sits beside the issue stage of an in-order pipeline and carries out two kinds of barrier. A memory barrier stops any later instruction from issuing until all data memory accesses that were already in flight have finished. It then lets issue resume and leaves the fetched stream alone. An instruction barrier waits until the whole pipeline has emptied. It then raises a one-cycle flush that throws away every instruction fetched so far, and it supplies the address of the instruction after the barrier so that fetch can start again from there. Instructions fetched again in this way run under the privilege, translation and protection state left by the instructions before the barrier.

The controller is a three-state machine: idle, draining and flushing. It takes a new barrier only while it is idle. A separate tracker holds the load-reserve reservation flag. A load-reserve sets the flag. Any store-conditional clears it, whether the store succeeds or fails, so a reservation made in one process cannot be paired with a store-conditional in another process after a switch.

Top module: `pipe_sync_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `issue_stall`, `fetch_flush` and `resv_valid` are 0 and `refetch_pc` is 0.
- R2: When `bar_valid` is high in the idle state with `bar_kind` equal to 2'b01 (memory barrier) or 2'b10 (instruction barrier), `issue_stall` is 1 in that same cycle, and the controller enters draining at the next clock edge.
- R3: A memory barrier keeps `issue_stall` high for every cycle in which `mem_pending` is non-zero. It does not wait for `pipe_empty`. In the first draining cycle where `mem_pending` is 0, `issue_stall` is still 1, and in the cycle after that it is 0.
- R4: A memory barrier never raises `fetch_flush`.
- R5: An instruction barrier keeps `fetch_flush` at 0 while `pipe_empty` is 0. It raises `fetch_flush` for exactly one cycle: the first draining cycle in which `pipe_empty` is 1.
- R6: In the cycle after the flush pulse (the flushing state), `issue_stall` stays 1 and `fetch_flush` is 0. In the cycle after that, the controller is idle again.
- R7: When a barrier is accepted, `refetch_pc` becomes `bar_pc` + 4 at the next edge. It then holds that value until another barrier is accepted.
- R8: A barrier offered while the controller is not idle is ignored. `refetch_pc` does not change, and the barrier already in progress ends on its own condition.
- R9: `lr_exec` sets `resv_valid` at the next clock edge.
- R10: `sc_exec` clears `resv_valid` at the next clock edge. When `lr_exec` and `sc_exec` are both high in the same cycle, the clear wins.
- R11: `bar_kind` values 2'b00 and 2'b11 are not barriers. With `bar_valid` high they cause no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bar_valid | input | 1 | A decoded barrier is present at issue |
| bar_kind | input | 2 | Barrier kind: 01 memory, 10 instruction, 00 and 11 none |
| bar_pc | input | PC_W | Address of the barrier instruction |
| mem_pending | input | CNT_W | Count of data memory accesses still in flight |
| pipe_empty | input | 1 | Every earlier instruction has completed |
| lr_exec | input | 1 | A load-reserve executes this cycle |
| sc_exec | input | 1 | A store-conditional executes this cycle |
| issue_stall | output | 1 | Hold issue of later instructions |
| fetch_flush | output | 1 | One-cycle pulse that discards fetched instructions |
| refetch_pc | output | PC_W | Address from which fetch restarts |
| resv_valid | output | 1 | A load-reserve reservation is outstanding |

## Verification
The assertions assume that the surrounding pipeline keeps `bar_valid`, `bar_kind` and `bar_pc` stable and meaningful only at issue. They also assume that `pipe_empty` and `mem_pending` describe instructions that are older than the barrier. No property depends on the two reservation inputs being mutually exclusive. The stimulus drives every input on the falling edge from a fixed table. It offers barriers in the idle state, with one deliberate exception: a barrier is offered during draining to show that it is ignored. It also drives `lr_exec` and `sc_exec` together once, to check which one wins.

// File: rtl/sync_ctrl_pkg.sv
package sync_ctrl_pkg;

    typedef enum logic [1:0] {
        BK_NONE  = 2'b00,
        BK_MEM   = 2'b01,
        BK_INSTR = 2'b10,
        BK_RSVD  = 2'b11
    } bar_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_DRAIN = 2'b01,
        ST_FLUSH = 2'b10
    } sync_state_e;

    localparam int unsigned INSTR_BYTES = 4;

    function automatic logic is_barrier(input bar_kind_e k);
        return (k == BK_MEM) || (k == BK_INSTR);
    endfunction

endpackage

// File: rtl/sync_fsm.sv
module sync_fsm
    import sync_ctrl_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bar_valid,
    input  bar_kind_e        bar_kind,
    input  logic [CNT_W-1:0] mem_pending,
    input  logic             pipe_empty,
    output logic             accept,
    output logic             stall,
    output logic             flush
);

    sync_state_e state_q, state_d;
    bar_kind_e   kind_q;
    logic        mem_drained;

    assign mem_drained = (mem_pending == '0);
    assign accept      = (state_q == ST_IDLE) && bar_valid && is_barrier(bar_kind);
    assign stall       = accept || (state_q != ST_IDLE);
    assign flush       = (state_q == ST_DRAIN) && (kind_q == BK_INSTR) && pipe_empty;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_DRAIN;
            ST_DRAIN: begin
                if (kind_q == BK_MEM) begin
                    if (mem_drained) state_d = ST_IDLE;
                end else if (pipe_empty) begin
                    state_d = ST_FLUSH;
                end
            end
            ST_FLUSH: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            kind_q  <= BK_NONE;
        end else begin
            state_q <= state_d;
            if (accept) kind_q <= bar_kind;
        end
    end

    AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (rst)
        flush |=> !flush); // R5
    AST_FLUSH_THEN_STALL: assert property (@(posedge clk) disable iff (rst)
        flush |=> stall); // R6
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DRAIN && kind_q == BK_MEM && !mem_drained) |=> stall); // R3
    AST_MEM_NO_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (kind_q == BK_MEM) |-> !flush); // R4

endmodule

// File: rtl/refetch_addr.sv
module refetch_addr
    import sync_ctrl_pkg::*;
#(
    parameter int unsigned PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            capture,
    input  logic [PC_W-1:0] bar_pc,
    output logic [PC_W-1:0] next_pc
);

    localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

    logic [PC_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst)          addr_q <= '0;
        else if (capture) addr_q <= bar_pc + STEP;
    end

    assign next_pc = addr_q;

    AST_REFETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(addr_q)); // R7

endmodule

// File: rtl/resv_tracker.sv
module resv_tracker (
    input  logic clk,
    input  logic rst,
    input  logic lr_exec,
    input  logic sc_exec,
    output logic resv_valid
);

    logic resv_q;

    always_ff @(posedge clk) begin
        if (rst)          resv_q <= 1'b0;
        else if (sc_exec) resv_q <= 1'b0;
        else if (lr_exec) resv_q <= 1'b1;
    end

    assign resv_valid = resv_q;

    AST_SC_CLEARS: assert property (@(posedge clk) disable iff (rst)
        sc_exec |=> !resv_valid); // R10
    AST_LR_SETS: assert property (@(posedge clk) disable iff (rst)
        (lr_exec && !sc_exec) |=> resv_valid); // R9

endmodule

// File: rtl/pipe_sync_ctrl.sv
module pipe_sync_ctrl
    import sync_ctrl_pkg::*;
#(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bar_valid,
    input  logic [1:0]       bar_kind,
    input  logic [PC_W-1:0]  bar_pc,
    input  logic [CNT_W-1:0] mem_pending,
    input  logic             pipe_empty,
    input  logic             lr_exec,
    input  logic             sc_exec,
    output logic             issue_stall,
    output logic             fetch_flush,
    output logic [PC_W-1:0]  refetch_pc,
    output logic             resv_valid
);

    logic accept;

    sync_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .bar_valid  (bar_valid),
        .bar_kind   (bar_kind_e'(bar_kind)),
        .mem_pending(mem_pending),
        .pipe_empty (pipe_empty),
        .accept     (accept),
        .stall      (issue_stall),
        .flush      (fetch_flush)
    );

    refetch_addr #(.PC_W(PC_W)) u_refetch (
        .clk    (clk),
        .rst    (rst),
        .capture(accept),
        .bar_pc (bar_pc),
        .next_pc(refetch_pc)
    );

    resv_tracker u_resv (
        .clk       (clk),
        .rst       (rst),
        .lr_exec   (lr_exec),
        .sc_exec   (sc_exec),
        .resv_valid(resv_valid)
    );

    AST_NO_FLUSH_UNSTALLED: assert property (@(posedge clk) disable iff (rst)
        !issue_stall |-> !fetch_flush); // R5

endmodule

// File: tb/pipe_sync_ctrl_tb.sv
module pipe_sync_ctrl_tb;

    localparam int PC_W  = 32;
    localparam int CNT_W = 4;
    localparam int NVEC  = 18;

    logic             clk = 1'b0;
    logic             rst;
    logic             bar_valid;
    logic [1:0]       bar_kind;
    logic [PC_W-1:0]  bar_pc;
    logic [CNT_W-1:0] mem_pending;
    logic             pipe_empty;
    logic             lr_exec;
    logic             sc_exec;
    logic             issue_stall;
    logic             fetch_flush;
    logic [PC_W-1:0]  refetch_pc;
    logic             resv_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pipe_sync_ctrl #(.PC_W(PC_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .bar_valid(bar_valid), .bar_kind(bar_kind),
        .bar_pc(bar_pc), .mem_pending(mem_pending), .pipe_empty(pipe_empty),
        .lr_exec(lr_exec), .sc_exec(sc_exec), .issue_stall(issue_stall),
        .fetch_flush(fetch_flush), .refetch_pc(refetch_pc), .resv_valid(resv_valid)
    );

    // {bar_valid, kind[1:0], pending[3:0], empty, lr, sc, exp_stall, exp_flush, exp_resv}
    localparam logic [12:0] VEC [NVEC] = '{
        13'b0_00_0000_0_0_0_0_0_0, // 0  idle
        13'b0_00_0000_0_1_0_0_0_0, // 1  R9 load-reserve
        13'b0_00_0000_0_0_0_0_0_1, // 2  R9 flag set
        13'b1_01_0010_1_0_0_1_0_1, // 3  R2 memory barrier accepted
        13'b0_00_0010_1_0_0_1_0_1, // 4  R3 pending, empty ignored
        13'b0_00_0001_1_0_0_1_0_1, // 5  R3
        13'b0_00_0000_0_0_0_1_0_1, // 6  R3/R4 drained, no flush
        13'b0_00_0000_0_0_0_0_0_1, // 7  R3 released
        13'b1_10_0000_0_0_0_1_0_1, // 8  R2 instruction barrier
        13'b0_00_0000_0_0_0_1_0_1, // 9  R5 not empty
        13'b0_00_0000_1_0_0_1_1_1, // 10 R5 flush pulse
        13'b0_00_0000_1_0_0_1_0_1, // 11 R6 flushing
        13'b0_00_0000_0_0_1_0_0_1, // 12 R6 idle, R10 sc
        13'b0_00_0000_0_0_0_0_0_0, // 13 R10 cleared
        13'b1_00_0000_0_0_0_0_0_0, // 14 R11 kind 00
        13'b1_11_0000_0_0_0_0_0_0, // 15 R11 kind 11
        13'b0_00_0000_0_1_1_0_0_0, // 16 R10 both
        13'b0_00_0000_0_0_0_0_0_0  // 17 R10 clear wins
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        bar_valid = 0; bar_kind = 2'b00; mem_pending = '0;
        pipe_empty = 0; lr_exec = 0; sc_exec = 0;
    endtask

    initial begin
        bar_pc = 32'h0000_0100;
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 stall in reset", {31'd0, issue_stall}, 0);
        chk("R1 flush in reset", {31'd0, fetch_flush}, 0);
        chk("R1 resv in reset", {31'd0, resv_valid}, 0);
        chk("R1 refetch in reset", refetch_pc, 0);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        #1;
        chk("R1 stall after reset", {31'd0, issue_stall}, 0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            bar_valid   = VEC[i][12];
            bar_kind    = VEC[i][11:10];
            mem_pending = VEC[i][9:6];
            pipe_empty  = VEC[i][5];
            lr_exec     = VEC[i][4];
            sc_exec     = VEC[i][3];
            #1;
            chk($sformatf("vec %0d stall (R2/R3/R6/R11)", i), {31'd0, issue_stall}, {31'd0, VEC[i][2]});
            chk($sformatf("vec %0d flush (R4/R5)", i), {31'd0, fetch_flush}, {31'd0, VEC[i][1]});
            chk($sformatf("vec %0d resv (R9/R10)", i), {31'd0, resv_valid}, {31'd0, VEC[i][0]});
        end

        // R7: capture address of instruction barrier
        @(negedge clk);
        idle_inputs();
        bar_valid = 1; bar_kind = 2'b10; bar_pc = 32'h0000_0200;
        @(negedge clk);
        bar_valid = 1; bar_kind = 2'b01; bar_pc = 32'h0000_0300; pipe_empty = 0;
        #1;
        chk("R7 refetch after accept", refetch_pc, 32'h0000_0204);
        @(negedge clk);
        #1;
        chk("R8 refetch unchanged while draining", refetch_pc, 32'h0000_0204);
        chk("R8 no flush before empty", {31'd0, fetch_flush}, 0);
        @(negedge clk);
        bar_valid = 0; pipe_empty = 1;
        #1;
        chk("R8 in-progress instruction barrier flushes", {31'd0, fetch_flush}, 1);
        @(negedge clk);
        #1;
        chk("R6 stall held while flushing", {31'd0, issue_stall}, 1);
        @(negedge clk);
        #1;
        chk("R6 idle after flushing", {31'd0, issue_stall}, 0);
        chk("R7 refetch held", refetch_pc, 32'h0000_0204);

        // R7: new memory barrier captures new address
        bar_valid = 1; bar_kind = 2'b01; bar_pc = 32'h0000_0300; mem_pending = 4'd3;
        @(negedge clk);
        bar_valid = 0;
        #1;
        chk("R7 refetch from memory barrier", refetch_pc, 32'h0000_0304);
        chk("R3 stall while pending", {31'd0, issue_stall}, 1);

        // reset mid-drain
        rst = 1;
        @(negedge clk);
        rst = 0;
        #1;
        chk("R1 stall cleared by reset", {31'd0, issue_stall}, 0);
        chk("R1 refetch cleared by reset", refetch_pc, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule